// File: doc/BRIEF.md
# Load-Store Alignment Unit

This block lies between a 32-bit processor datapath and a memory organised in whole words. For a load it takes the addressed memory word, selects the byte, halfword or word that the access names, and returns a 32-bit register value. That value is sign-extended or zero-extended as the opcode asks. For a store it lays the low byte or halfword of the source register across the data lanes and raises a 4-bit byte-enable mask, so that memory writes only the addressed lanes.

The effective address (base register plus offset) is formed upstream. Only its two low bits enter this block. Lanes are numbered big-endian: the lowest byte address maps to the most significant bits of the word. All three outputs are registered and appear one clock after their inputs.

Top module: `lsu_align_unit`

## Requirements
- R1: While rst_n is low, load_data, store_data and byte_en are all zero.
- R2: Each output reflects the inputs sampled at the preceding rising clock edge. A change of inputs between edges does not alter the outputs.
- R3: A byte load (acc_size = 00) with acc_unsigned = 0 returns the selected byte sign-extended to 32 bits. Address offset 00, 01, 10 and 11 selects mem_rdata bits [31:24], [23:16], [15:8] and [7:0] respectively.
- R4: A byte load with acc_unsigned = 1 returns the same selected byte with the upper 24 bits zero.
- R5: A halfword load (acc_size = 01) with acc_unsigned = 0 returns mem_rdata[31:16] when addr_lo[1] = 0 and mem_rdata[15:0] when addr_lo[1] = 1, sign-extended. addr_lo[0] has no effect.
- R6: A halfword load with acc_unsigned = 1 returns the same halfword with the upper 16 bits zero.
- R7: A word load (acc_size = 10 or 11) returns all of mem_rdata for every addr_lo value.
- R8: For a load (is_store = 0), byte_en is 0000 and store_data is zero. For a store, load_data is zero.
- R9: A byte store drives byte_en 1000, 0100, 0010 or 0001 for addr_lo 00, 01, 10 or 11. store_data carries src_data[7:0] in all four byte lanes.
- R10: A halfword store drives byte_en 1100 when addr_lo[1] = 0 and 0011 when addr_lo[1] = 1. store_data carries src_data[15:0] in both halves, and addr_lo[0] has no effect.
- R11: A word store drives byte_en 1111 and passes src_data unchanged for every addr_lo value.
- R12: acc_unsigned has no effect on stores or on word loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| is_store | input | 1 | 1 = store access, 0 = load access |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_unsigned | input | 1 | 1 = zero-extend loaded value, 0 = sign-extend |
| addr_lo | input | 2 | Low two bits of the effective address |
| mem_rdata | input | 32 | Word read from data memory |
| src_data | input | 32 | Source register value to store |
| load_data | output | 32 | Extended value for the destination register |
| store_data | output | 32 | Lane-replicated write data for memory |
| byte_en | output | 4 | Byte write enables, bit 3 = lowest address lane |

## Verification
The load tests use a memory word in which each lane has a different sign bit: 0x80 and 0xC3 with the top bit set, 0x7F and 0x12 with it clear. A wrong lane choice therefore gives a different value, and so does a wrong extension. Halfword loads use 0x8001 beside 0x7FFE, and they repeat each access with the odd address bit set, so a decoder that reads addr_lo[0] is caught. Stores use a source word whose bytes all differ, so that replication of the wrong byte or half shows. Each size and address is also repeated with the unsigned flag set, and a word access is tried with both size codes, to confirm the cases that must not change.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } acc_size_e;

    function automatic logic size_is_word(acc_size_e sz);
        return sz[1];
    endfunction

endpackage

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]                 rdata,
    input  logic [$clog2(DATA_W/8)-1:0]       addr,
    input  acc_size_e                         size,
    input  logic                              zext,
    output logic [DATA_W-1:0]                 result
);
    localparam int LANES  = DATA_W / 8;
    localparam int HALVES = LANES / 2;
    localparam int ADDR_W = $clog2(LANES);

    logic [7:0]  lane_byte [LANES];
    logic [15:0] lane_half [HALVES];

    for (genvar g = 0; g < LANES; g++) begin : g_bytes
        assign lane_byte[g] = rdata[DATA_W-1-8*g -: 8];
    end
    for (genvar h = 0; h < HALVES; h++) begin : g_halves
        assign lane_half[h] = rdata[DATA_W-1-16*h -: 16];
    end

    logic [7:0]  pick_b;
    logic [15:0] pick_h;

    always_comb begin
        pick_b = lane_byte[addr];
        pick_h = lane_half[addr[ADDR_W-1:1]];
        if (size_is_word(size)) begin
            result = rdata;
        end else if (size == SZ_HALF) begin
            result = zext ? {{(DATA_W-16){1'b0}}, pick_h}
                          : {{(DATA_W-16){pick_h[15]}}, pick_h};
        end else begin
            result = zext ? {{(DATA_W-8){1'b0}}, pick_b}
                          : {{(DATA_W-8){pick_b[7]}}, pick_b};
        end
    end
endmodule

// File: rtl/lsu_store_replicate.sv
module lsu_store_replicate
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] result
);
    localparam int LANES  = DATA_W / 8;
    localparam int HALVES = LANES / 2;

    always_comb begin
        if (size_is_word(size)) begin
            result = src;
        end else if (size == SZ_HALF) begin
            result = {HALVES{src[15:0]}};
        end else begin
            result = {LANES{src[7:0]}};
        end
    end
endmodule

// File: rtl/lsu_byte_mask.sv
module lsu_byte_mask
    import lsu_align_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] addr,
    input  acc_size_e                size,
    input  logic                     is_store,
    output logic [LANES-1:0]         en
);
    localparam int ADDR_W = $clog2(LANES);
    localparam int HIDX_W = ADDR_W - 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit_b;
        logic hit_h;
        assign hit_b = (addr == ADDR_W'(g));
        assign hit_h = (addr[ADDR_W-1:1] == HIDX_W'(g / 2));
        always_comb begin
            if (!is_store) begin
                en[LANES-1-g] = 1'b0;
            end else if (size_is_word(size)) begin
                en[LANES-1-g] = 1'b1;
            end else if (size == SZ_HALF) begin
                en[LANES-1-g] = hit_h;
            end else begin
                en[LANES-1-g] = hit_b;
            end
        end
    end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          is_store,
    input  logic [1:0]                    acc_size,
    input  logic                          acc_unsigned,
    input  logic [$clog2(DATA_W/8)-1:0]   addr_lo,
    input  logic [DATA_W-1:0]             mem_rdata,
    input  logic [DATA_W-1:0]             src_data,
    output logic [DATA_W-1:0]             load_data,
    output logic [DATA_W-1:0]             store_data,
    output logic [DATA_W/8-1:0]           byte_en
);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] ld;
        logic [DATA_W-1:0] st;
        logic [LANES-1:0]  be;
    } out_regs_t;

    out_regs_t regs_d, regs_q;

    acc_size_e         size_e;
    logic [DATA_W-1:0] ld_val;
    logic [DATA_W-1:0] st_val;
    logic [LANES-1:0]  be_val;

    assign size_e = acc_size_e'(acc_size);

    lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
        .rdata  (mem_rdata),
        .addr   (addr_lo),
        .size   (size_e),
        .zext   (acc_unsigned),
        .result (ld_val)
    );

    lsu_store_replicate #(.DATA_W(DATA_W)) u_replicate (
        .src    (src_data),
        .size   (size_e),
        .result (st_val)
    );

    lsu_byte_mask #(.LANES(LANES)) u_mask (
        .addr     (addr_lo),
        .size     (size_e),
        .is_store (is_store),
        .en       (be_val)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.ld = is_store ? '0 : ld_val;
        regs_d.st = is_store ? st_val : '0;
        regs_d.be = be_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign load_data  = regs_q.ld;
    assign store_data = regs_q.st;
    assign byte_en    = regs_q.be;
endmodule

// File: rtl/lsu_align_unit_chk.sv
module lsu_align_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          is_store,
    input logic [1:0]                    acc_size,
    input logic                          acc_unsigned,
    input logic [$clog2(DATA_W/8)-1:0]   addr_lo,
    input logic [DATA_W-1:0]             mem_rdata,
    input logic [DATA_W-1:0]             src_data,
    input logic [DATA_W-1:0]             load_data,
    input logic [DATA_W-1:0]             store_data,
    input logic [DATA_W/8-1:0]           byte_en
);
    localparam int LANES = DATA_W / 8;

    a_r3_signed_byte_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_store && acc_size == 2'b00 && !acc_unsigned)
        |=> load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}});

    a_r4_unsigned_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_store && acc_size == 2'b00 && acc_unsigned)
        |=> load_data[DATA_W-1:8] == '0);

    a_r8_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !is_store |=> (byte_en == '0 && store_data == '0));

    a_r8_store_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        is_store |=> load_data == '0);

    a_r9_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && acc_size == 2'b00) |=> $countones(byte_en) == 1);

    a_r9_byte_replicated: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && acc_size == 2'b00)
        |=> store_data == {LANES{$past(src_data[7:0])}});

    a_r10_half_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && acc_size == 2'b01) |=> $countones(byte_en) == 2);

    a_r11_word_full: assert property (@(posedge clk) disable iff (!rst_n)
        (is_store && acc_size[1])
        |=> (&byte_en && store_data == $past(src_data)));
endmodule

bind lsu_align_unit lsu_align_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .is_store     (is_store),
    .acc_size     (acc_size),
    .acc_unsigned (acc_unsigned),
    .addr_lo      (addr_lo),
    .mem_rdata    (mem_rdata),
    .src_data     (src_data),
    .load_data    (load_data),
    .store_data   (store_data),
    .byte_en      (byte_en)
);

// File: tb/lsu_align_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_align_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        is_store = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic        acc_unsigned = 1'b0;
    logic [1:0]  addr_lo = 2'b00;
    logic [31:0] mem_rdata = '0;
    logic [31:0] src_data = '0;
    logic [31:0] load_data;
    logic [31:0] store_data;
    logic [3:0]  byte_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lsu_align_unit dut_i (
        .clk(clk), .rst_n(rst_n), .is_store(is_store), .acc_size(acc_size),
        .acc_unsigned(acc_unsigned), .addr_lo(addr_lo), .mem_rdata(mem_rdata),
        .src_data(src_data), .load_data(load_data), .store_data(store_data),
        .byte_en(byte_en)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge register, sample at next falling edge.
    task automatic access(logic st, logic [1:0] sz, logic uns, logic [1:0] a,
                          logic [31:0] rd, logic [31:0] src);
        @(negedge clk);
        is_store = st; acc_size = sz; acc_unsigned = uns; addr_lo = a;
        mem_rdata = rd; src_data = src;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        is_store = 1'b1; acc_size = 2'b10; src_data = 32'hFFFF_FFFF;
        mem_rdata = 32'hFFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        check("R1 load_data", load_data, 32'h0);
        check("R1 store_data", store_data, 32'h0);
        check("R1 byte_en", {28'h0, byte_en}, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        access(1'b0, 2'b10, 1'b0, 2'b00, 32'h1111_2222, 32'h0);
        check("R2 settled", load_data, 32'h1111_2222);
        mem_rdata = 32'h3333_4444;
        #1;
        check("R2 held between edges", load_data, 32'h1111_2222);
        @(posedge clk);
        @(negedge clk);
        check("R2 next edge", load_data, 32'h3333_4444);
    endtask

    task automatic t_byte_loads();
        logic [31:0] rd = 32'h807F_C312;
        logic [31:0] sgn [4] = '{32'hFFFF_FF80, 32'h0000_007F, 32'hFFFF_FFC3, 32'h0000_0012};
        logic [31:0] uns [4] = '{32'h0000_0080, 32'h0000_007F, 32'h0000_00C3, 32'h0000_0012};
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 2'b00, 1'b0, 2'(i), rd, 32'h0);
            check("R3 signed byte", load_data, sgn[i]);
            check("R8 load no enables", {28'h0, byte_en}, 32'h0);
            check("R8 load no store data", store_data, 32'h0);
            access(1'b0, 2'b00, 1'b1, 2'(i), rd, 32'h0);
            check("R4 unsigned byte", load_data, uns[i]);
        end
    endtask

    task automatic t_half_loads();
        logic [31:0] rd = 32'h8001_7FFE;
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 2'b01, 1'b0, 2'(i), rd, 32'h0);
            check("R5 signed half", load_data, (i < 2) ? 32'hFFFF_8001 : 32'h0000_7FFE);
            access(1'b0, 2'b01, 1'b1, 2'(i), rd, 32'h0);
            check("R6 unsigned half", load_data, (i < 2) ? 32'h0000_8001 : 32'h0000_7FFE);
        end
    endtask

    task automatic t_word_loads();
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 2'b10, 1'b0, 2'(i), 32'hDEAD_BEEF, 32'h0);
            check("R7 word load size 10", load_data, 32'hDEAD_BEEF);
            access(1'b0, 2'b11, 1'b1, 2'(i), 32'hDEAD_BEEF, 32'h0);
            check("R12 word load size 11 unsigned", load_data, 32'hDEAD_BEEF);
        end
    endtask

    task automatic t_byte_stores();
        logic [3:0] be [4] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001};
        for (int i = 0; i < 4; i++) begin
            for (int u = 0; u < 2; u++) begin
                access(1'b1, 2'b00, u[0], 2'(i), 32'hFFFF_FFFF, 32'h1234_56A5);
                check(u ? "R12 byte enable unsigned" : "R9 byte enable",
                      {28'h0, byte_en}, {28'h0, be[i]});
                check("R9 byte data", store_data, 32'hA5A5_A5A5);
                check("R8 store no load data", load_data, 32'h0);
            end
        end
    endtask

    task automatic t_half_stores();
        for (int i = 0; i < 4; i++) begin
            for (int u = 0; u < 2; u++) begin
                access(1'b1, 2'b01, u[0], 2'(i), 32'h0, 32'h1234_56A5);
                check(u ? "R12 half enable unsigned" : "R10 half enable",
                      {28'h0, byte_en}, (i < 2) ? 32'hC : 32'h3);
                check("R10 half data", store_data, 32'h56A5_56A5);
            end
        end
    endtask

    task automatic t_word_stores();
        for (int i = 0; i < 4; i++) begin
            access(1'b1, 2'(2 + (i % 2)), i[1], 2'(i), 32'h0, 32'h1234_56A5);
            check("R11 word enable", {28'h0, byte_en}, 32'hF);
            check("R11 word data", store_data, 32'h1234_56A5);
        end
    endtask

    initial begin
        t_reset();
        t_latency();
        t_byte_loads();
        t_half_loads();
        t_word_loads();
        t_byte_stores();
        t_half_stores();
        t_word_stores();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule